// File: doc/BRIEF.md
# Scaled Fractional Multiplier

This block is the signed fractional multiply unit of a 16-bit fixed-point DSP datapath. It multiplies two Q15 operands into a 32-bit product. It then moves that product left or right by a distance drawn from a small fixed set, and only after that cuts it down to one 16-bit result word. Because the scaling acts on the untruncated product, a left move pulls genuine low-order product bits into the result. A truncating multiply followed by a separate shift would fill those positions with zeros.

The integer word length of a product is the sum of the integer word lengths of its operands. A compiler that has measured the real signal ranges uses the output shift to put the product back into the format it wants. It may deliberately discard top bits that it has shown to be redundant, so the block neither saturates nor flags overflow. A build parameter selects the size of the shift set: eight, four or two distances. The result is registered, with one clock of latency.

Top module: `fmul_scaled`

## Requirements
- R1: With shift code 0 the result is bits [30:15] of the 32-bit signed product of the two 16-bit signed operands. Lower bits are truncated and no rounding is applied.
- R2: The shift code is a 3-bit two's-complement value v, and the product moves left by -v places (v < 0) or right by v places (v > 0) before bits [30:15] are taken. In the eight-entry build every code from -4 (4 left) through +3 (3 right) is honoured.
- R3: A left move brings real product bits into the result. For example, 0x0001 times 0x4000 with code -1 yields 0x0001.
- R4: Right moves are arithmetic and copy the product sign into the vacated upper positions. For example, 0x8000 times 0x4000 with code +3 yields 0xF800.
- R5: Bits pushed above the result word by a left move are lost without saturation. For example, 0x4000 times 0x4000 with code -2 yields 0x8000.
- R6: 0x8000 times 0x8000 with code 0 yields 0x8000 (wrap, no saturation).
- R7: The four-entry build honours codes -2, -1, 0 and +1. Every other code acts as code 0.
- R8: The two-entry build honours codes -1 and 0. Every other code acts as code 0.
- R9: `out_vld` equals the value of `in_vld` at the previous rising clock edge, and each result appears one clock after its operands are accepted.
- R10: While `in_vld` is low, `out_res` keeps its last value, whatever happens on the operands and the code.
- R11: A synchronous active-high reset clears `out_vld` and `out_res` at the next edge. If reset and `in_vld` are both high at the same edge, the reset takes precedence.
- R12: A zero operand gives a zero result for every shift code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operands and code are accepted at this edge |
| opnd_a | input | 16 | First Q15 operand, two's complement |
| opnd_b | input | 16 | Second Q15 operand, two's complement |
| shf_code | input | 3 | Signed output shift code |
| out_vld | output | 1 | Result register holds a new value |
| out_res | output | 16 | Scaled, truncated Q15 result |

## Verification
Reset and an operand acceptance can land on the same clock edge. The bench provokes this by holding `in_vld` high with non-zero operands while pulsing reset. It then expects both outputs to read zero instead of the product that was offered. The other collision is a left move that both imports low product bits and wraps the top of the product. Operand pairs near full scale, paired with every code, are compared against an arithmetic model on the eight-, four- and two-entry builds side by side.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  // Largest left distance for a given shift-set size; the remaining
  // entries of the set are right distances, one place apart.
  function automatic int left_max(input int set_size);
    case (set_size)
      8:       return 4;
      4:       return 2;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/fmul_mult.sv
module fmul_mult #(
  parameter int DATA_W = 16,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] ea;
  logic signed [PROD_W-1:0] eb;

  always_comb begin
    ea     = {{DATA_W{a_i[DATA_W-1]}}, a_i};
    eb     = {{DATA_W{b_i[DATA_W-1]}}, b_i};
    prod_o = ea * eb;
  end
endmodule

// File: rtl/fmul_decode.sv
module fmul_decode
  import fmul_pkg::*;
#(
  parameter int CODE_W    = 3,
  parameter int SHIFT_SET = 8,
  localparam int LMAX     = left_max(SHIFT_SET)
) (
  input  logic [CODE_W-1:0]    code_i,
  output logic [SHIFT_SET-1:0] sel_o
);
  // Entry k moves the product left by LMAX-k places, so its code is k-LMAX.
  logic [SHIFT_SET-1:0] hit;

  for (genvar k = 0; k < SHIFT_SET; k++) begin : g_hit
    localparam logic signed [CODE_W-1:0] KCODE = CODE_W'(k - LMAX);
    assign hit[k] = ($signed(code_i) == KCODE);
  end

  // An unsupported code falls back to the no-shift entry.
  always_comb begin
    sel_o = hit;
    if (hit == '0) sel_o[LMAX] = 1'b1;
  end
endmodule

// File: rtl/fmul_align.sv
module fmul_align
  import fmul_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SHIFT_SET = 8,
  localparam int PROD_W   = 2 * DATA_W,
  localparam int LMAX     = left_max(SHIFT_SET),
  localparam int FRAC     = DATA_W - 1,
  localparam int EXT_W    = PROD_W + SHIFT_SET - 1
) (
  input  logic [PROD_W-1:0]    prod_i,
  input  logic [SHIFT_SET-1:0] sel_i,
  output logic [DATA_W-1:0]    res_o
);
  // Product sign-extended on top and moved up by LMAX, so that every
  // candidate window is a constant slice of one vector.
  logic [EXT_W-1:0]  ext;
  logic [DATA_W-1:0] cand [SHIFT_SET];
  logic              unused_ext;

  always_comb begin
    ext = {{(EXT_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};
    ext = ext << LMAX;
  end

  for (genvar k = 0; k < SHIFT_SET; k++) begin : g_win
    assign cand[k] = ext[FRAC + k +: DATA_W];
  end

  // Truncated low bits and the spare sign copy never reach the result.
  assign unused_ext = ^{ext[EXT_W-1], ext[FRAC-1:0]};

  always_comb begin
    res_o = '0;
    for (int k = 0; k < SHIFT_SET; k++) begin
      if (sel_i[k]) res_o = res_o | cand[k];
    end
  end
endmodule

// File: rtl/fmul_scaled.sv
module fmul_scaled #(
  parameter int DATA_W    = 16,
  parameter int CODE_W    = 3,
  parameter int SHIFT_SET = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [CODE_W-1:0] shf_code,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_res
);
  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0]    prod;
  logic [SHIFT_SET-1:0] sel;
  logic [DATA_W-1:0]    res_c;
  logic                 vld_q;
  logic [DATA_W-1:0]    res_q;

  fmul_mult #(.DATA_W(DATA_W)) u_mult (
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .prod_o (prod)
  );

  fmul_decode #(.CODE_W(CODE_W), .SHIFT_SET(SHIFT_SET)) u_dec (
    .code_i (shf_code),
    .sel_o  (sel)
  );

  fmul_align #(.DATA_W(DATA_W), .SHIFT_SET(SHIFT_SET)) u_align (
    .prod_i (prod),
    .sel_i  (sel),
    .res_o  (res_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) res_q <= res_c;
    end
  end

  assign out_vld = vld_q;
  assign out_res = res_q;
endmodule

// File: rtl/fmul_scaled_chk.sv
module fmul_scaled_chk #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [CODE_W-1:0] shf_code,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_res
);
  localparam logic [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  p_vld_rise_r9: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  p_vld_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_res));

  p_clear_r11: assert property (@(posedge clk)
    rst |=> (!out_vld && out_res == '0));

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && opnd_a == MINV && opnd_b == MINV && shf_code == '0)
      |=> out_res == MINV);

  p_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (opnd_a == '0 || opnd_b == '0)) |=> out_res == '0);
endmodule

bind fmul_scaled fmul_scaled_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_vld   (in_vld),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .shf_code (shf_code),
  .out_vld  (out_vld),
  .out_res  (out_res)
);

// File: tb/sim_fmul_scaled.sv
`timescale 1ns/1ps
module sim_fmul_scaled;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [2:0]  shf_code = '0;
  logic        vld8, vld4, vld2;
  logic [15:0] res8, res4, res2;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fmul_scaled #(.SHIFT_SET(8)) u0 (.clk(clk), .rst(rst), .in_vld(in_vld),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shf_code(shf_code),
    .out_vld(vld8), .out_res(res8));
  fmul_scaled #(.SHIFT_SET(4)) u1 (.clk(clk), .rst(rst), .in_vld(in_vld),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shf_code(shf_code),
    .out_vld(vld4), .out_res(res4));
  fmul_scaled #(.SHIFT_SET(2)) u2 (.clk(clk), .rst(rst), .in_vld(in_vld),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shf_code(shf_code),
    .out_vld(vld2), .out_res(res2));

  function automatic logic [15:0] model(logic [15:0] a, logic [15:0] b,
                                        logic [2:0] code, int set);
    int v;
    int n;
    bit ok;
    longint p;
    logic [63:0] q;
    v = $signed(code);
    case (set)
      8:       ok = 1'b1;
      4:       ok = (v >= -2 && v <= 1);
      default: ok = (v == -1 || v == 0);
    endcase
    n = ok ? -v : 0;
    p = longint'($signed(a)) * longint'($signed(b));
    if (n >= 0) p = p <<< n;
    else        p = p >>> (-n);
    q = p;
    return q[30:15];
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Offer one operand set for a single clock, then stop at the negedge
  // after the capturing edge with in_vld low again.
  task automatic drive(logic [15:0] a, logic [15:0] b, logic [2:0] code);
    @(negedge clk);
    in_vld = 1'b1; opnd_a = a; opnd_b = b; shf_code = code;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic chk_all(string tag, logic [15:0] a, logic [15:0] b,
                         logic [2:0] code);
    chk({tag, " set8 (R2)"}, res8, model(a, b, code, 8));
    chk({tag, " set4 (R7)"}, res4, model(a, b, code, 4));
    chk({tag, " set2 (R8)"}, res2, model(a, b, code, 2));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11 reset vld", {15'd0, vld8}, 16'd0);
    chk("R11 reset res", res8, 16'h0000);
  endtask

  task automatic t_plain();
    drive(16'h4000, 16'h4000, 3'd0);
    chk("R1 0.5*0.5", res8, 16'h2000);
    drive(16'h7FFF, 16'h7FFF, 3'd0);
    chk("R1 max*max", res8, 16'h7FFE);
    drive(16'hC000, 16'h4000, 3'd0);
    chk("R1 -0.5*0.5", res8, 16'hE000);
    drive(16'h0003, 16'h4000, 3'd0);
    chk("R1 truncation", res8, 16'h0001);
  endtask

  task automatic t_sweep();
    logic [15:0] av [4] = '{16'h7FFF, 16'h8000, 16'h1234, 16'hA5C3};
    logic [15:0] bv [4] = '{16'h8001, 16'h7FFF, 16'hEDCB, 16'h3C5A};
    for (int i = 0; i < 4; i++) begin
      for (int c = 0; c < 8; c++) begin
        drive(av[i], bv[i], 3'(c));
        chk_all("R2 sweep", av[i], bv[i], 3'(c));
      end
    end
  endtask

  task automatic t_lowbits();
    drive(16'h0001, 16'h4000, 3'b111);
    chk("R3 low bit pulled in", res8, 16'h0001);
    chk("R8 code -1 in set2", res2, 16'h0001);
  endtask

  task automatic t_right();
    drive(16'h8000, 16'h4000, 3'b011);
    chk("R4 arithmetic right 3", res8, 16'hF800);
    chk("R7 code +3 ignored set4", res4, 16'hC000);
    chk("R8 code +3 ignored set2", res2, 16'hC000);
  endtask

  task automatic t_wrap();
    drive(16'h4000, 16'h4000, 3'b110);
    chk("R5 left 2 wraps", res8, 16'h8000);
    chk("R7 left 2 in set4", res4, 16'h8000);
    chk("R8 code -2 ignored set2", res2, 16'h2000);
    drive(16'h4000, 16'h4000, 3'b100);
    chk("R5 left 4 top bits lost", res8, 16'h0000);
    chk("R7 code -4 ignored set4", res4, 16'h2000);
  endtask

  task automatic t_minus_one();
    drive(16'h8000, 16'h8000, 3'd0);
    chk("R6 -1*-1 wraps", res8, 16'h8000);
    chk("R6 model agrees", res8, model(16'h8000, 16'h8000, 3'd0, 8));
  endtask

  task automatic t_zero();
    drive(16'h0000, 16'h7FFF, 3'b100);
    chk("R12 zero operand left 4", res8, 16'h0000);
    drive(16'h8000, 16'h0000, 3'b011);
    chk("R12 zero operand right 3", res8, 16'h0000);
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_vld = 1'b1; opnd_a = 16'h2000; opnd_b = 16'h2000; shf_code = 3'd0;
    chk("R9 vld low before edge", {15'd0, vld8}, 16'd0);
    @(negedge clk);
    chk("R9 vld one clock later", {15'd0, vld8}, 16'd1);
    chk("R9 result one clock later", res8, 16'h0800);
    opnd_a = 16'h4000;
    @(negedge clk);
    chk("R9 back-to-back result", res8, 16'h1000);
    in_vld = 1'b0;
    @(negedge clk);
    chk("R9 vld drops", {15'd0, vld8}, 16'd0);
  endtask

  task automatic t_hold();
    drive(16'h3000, 16'h4000, 3'd0);
    opnd_a = 16'h7FFF; opnd_b = 16'h7FFF; shf_code = 3'b100;
    repeat (3) @(negedge clk);
    chk("R10 result held", res8, 16'h1800);
  endtask

  task automatic t_reset_collide();
    drive(16'h4000, 16'h4000, 3'd0);
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b1; opnd_a = 16'h7FFF; opnd_b = 16'h7FFF;
    @(negedge clk);
    rst = 1'b0; in_vld = 1'b0;
    chk("R11 reset beats valid vld", {15'd0, vld8}, 16'd0);
    chk("R11 reset beats valid res", res8, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_sweep();
    t_lowbits();
    t_right();
    t_wrap();
    t_minus_one();
    t_zero();
    t_latency();
    t_hold();
    t_reset_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule